// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling ADC Interface Model

This block is a synthesizable device-side model of the digital face of a two-channel, 12-bit analog-to-digital converter that samples both channels at once. Four ready-made sample words (two inputs on channel one, two on channel two) arrive on input ports in offset-binary form. A falling edge on the active-low start input freezes all four at once and raises a busy flag for a fixed number of clock cycles that stands in for the conversion time. When busy drops, the frozen words become the readable results.

A host reads the results over a parallel bus that is modelled as data plus an output-enable, standing in for three-state pins. A read lasts while chip-select and read are both low. A channel-select input picks the channel, and an internal pointer steps through the two inputs of that channel, one per read. The enable comes on a programmable number of cycles after a read begins and goes off a programmable number of cycles after it ends. A parameter picks the output coding: twos complement for bipolar ranges or straight binary for a unipolar range.

Top module: `dual_adc_if`

## Requirements
- R1: When the start input is sampled low one cycle after it was sampled high and busy is low, all four sample ports are captured in that cycle and busy is high from the next cycle for exactly CONV_CYCLES cycles.
- R2: A falling start edge while busy is high has no effect: busy ends on the schedule of the first edge and the results hold the values captured by the first edge.
- R3: Results of a conversion become readable in the cycle busy falls; a read that starts while busy is high returns a word of the previous conversion.
- R4: data_oe rises ACCESS_DLY clock edges after cs_n and rd_n are both first sampled low; whenever data_oe is low, data_out is all zeros.
- R5: data_oe falls RELEASE_DLY clock edges after the first edge that samples cs_n or rd_n high.
- R6: With chan_sel low, reads return channel-one input 1 and then input 2. With chan_sel high, they return channel-two input 1 and then input 2. Further reads on the same chan_sel level keep alternating.
- R7: The input pointer returns to input 1 when a conversion completes and when a read starts with chan_sel at a different level than the previous read.
- R8: With TWOS_COMP=1 the word read is the sample with bit 11 (the MSB) inverted; with TWOS_COMP=0 it is the sample unchanged. The MSB always sits on data_out bit 11.
- R9: A read whose first cycle coincides with the completion edge returns the previous conversion's word, and the next read on the same chan_sel returns input 1 of the new conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| convst_n | input | 1 | Active-low convert start; a falling edge starts a conversion |
| samp_a1 | input | 12 | Channel one, input 1 sample (offset binary) |
| samp_a2 | input | 12 | Channel one, input 2 sample |
| samp_b1 | input | 12 | Channel two, input 1 sample |
| samp_b2 | input | 12 | Channel two, input 2 sample |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| chan_sel | input | 1 | Channel select: 0 = channel one, 1 = channel two |
| busy | output | 1 | High while a conversion is in progress |
| data_oe | output | 1 | Bus drive enable (low means high impedance) |
| data_out | output | 12 | Result word, zero when not enabled |

## Verification
Two events can fall on the same clock edge: the end of a conversion, which loads new results and resets the pointer, and the start of a read, which picks a word and advances the pointer. The bench counts busy cycles from the start edge and places the read strobe so that its first sampled cycle is the completion edge. The word returned must come from the previous conversion. The read after it must return input 1 of the new conversion, which shows that the completion's pointer reset overrides the read's advance. A second collision, a start edge that arrives while busy is high, is judged by the busy length and by the words read afterwards.

// File: rtl/dual_adc_if.sv
module dual_adc_if #(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 300,
  parameter int ACCESS_DLY  = 2,
  parameter int RELEASE_DLY = 2,
  parameter bit TWOS_COMP   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convst_n,
  input  logic [DATA_W-1:0] samp_a1,
  input  logic [DATA_W-1:0] samp_a2,
  input  logic [DATA_W-1:0] samp_b1,
  input  logic [DATA_W-1:0] samp_b2,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              chan_sel,
  output logic              busy,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_out
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int AW = $clog2(ACCESS_DLY + 1);
  localparam int RW = $clog2(RELEASE_DLY + 1);

  logic                    convst_q, busy_q, act_q, ptr, last_sel, oe_q;
  logic [CW-1:0]           conv_cnt;
  logic [AW-1:0]           on_cnt;
  logic [RW-1:0]           off_cnt;
  logic [3:0][DATA_W-1:0]  hold, res;
  logic [DATA_W-1:0]       dout_q;

  function automatic logic [DATA_W-1:0] enc(input logic [DATA_W-1:0] s);
    enc = TWOS_COMP ? {~s[DATA_W-1], s[DATA_W-2:0]} : s;
  endfunction

  wire act      = ~cs_n & ~rd_n;
  wire rd_start = act & ~act_q;
  wire start    = convst_q & ~convst_n & ~busy_q;
  wire done     = busy_q && (conv_cnt == '0);
  wire idx      = (chan_sel != last_sel) ? 1'b0 : ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      convst_q <= 1'b1;
      act_q    <= 1'b0;
      busy_q   <= 1'b0;
      conv_cnt <= '0;
      hold     <= '0;
      res      <= '0;
      dout_q   <= '0;
      ptr      <= 1'b0;
      last_sel <= 1'b0;
    end else begin
      convst_q <= convst_n;
      act_q    <= act;
      if (start) begin
        hold     <= {samp_b2, samp_b1, samp_a2, samp_a1};
        busy_q   <= 1'b1;
        conv_cnt <= CW'(CONV_CYCLES - 1);
      end else if (busy_q) begin
        if (done) begin
          busy_q <= 1'b0;
          res    <= hold;
        end else begin
          conv_cnt <= conv_cnt - 1'b1;
        end
      end
      if (rd_start) begin
        dout_q   <= enc(res[{chan_sel, idx}]);
        last_sel <= chan_sel;
        ptr      <= ~idx;
      end
      if (done) ptr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_cnt  <= '0;
      off_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (act) begin
      off_cnt <= '0;
      if (on_cnt != AW'(ACCESS_DLY)) on_cnt <= on_cnt + 1'b1;
      if (on_cnt >= AW'(ACCESS_DLY - 1)) oe_q <= 1'b1;
    end else begin
      on_cnt <= '0;
      if (off_cnt != RW'(RELEASE_DLY)) off_cnt <= off_cnt + 1'b1;
      if (off_cnt >= RW'(RELEASE_DLY - 1)) oe_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign data_oe  = oe_q;
  assign data_out = oe_q ? dout_q : '0;

  logic [CW-1:0] bsy_len;
  always_ff @(posedge clk) begin
    if (!rst_n)      bsy_len <= '0;
    else if (busy_q) bsy_len <= bsy_len + 1'b1;
    else             bsy_len <= '0;
  end

  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n) && !busy |=> busy);
  p_busy_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> bsy_len == CW'(CONV_CYCLES));
  p_busy_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> bsy_len < CW'(CONV_CYCLES));
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(hold));
  p_ptr_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !ptr);
  p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == '0);
  p_oe_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> !cs_n && !rd_n);
  p_oe_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_oe) |-> cs_n || rd_n);
endmodule

// File: tb/test_dual_adc_if.sv
module test_dual_adc_if;
  localparam int W = 12, CONV = 20, ACC = 2, REL = 2;

  logic clk = 1'b0, rst_n = 1'b0, convst_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, chan_sel = 1'b0;
  logic [W-1:0] a1 = '0, a2 = '0, b1 = '0, b2 = '0;
  logic busy, oe, busy_b, oe_b;
  logic [W-1:0] dout, dout_b;
  int checks = 0, errors = 0, bcnt = 0, last_len = 0;
  logic [W-1:0] rawq[$];
  string tagq[$];
  logic oe_prev = 1'b0;

  always #5 clk = ~clk;

  dual_adc_if #(.DATA_W(W), .CONV_CYCLES(CONV), .ACCESS_DLY(ACC), .RELEASE_DLY(REL), .TWOS_COMP(1'b1))
    i_dual_adc_if (.clk, .rst_n, .convst_n, .samp_a1(a1), .samp_a2(a2), .samp_b1(b1), .samp_b2(b2),
                   .cs_n, .rd_n, .chan_sel, .busy(busy), .data_oe(oe), .data_out(dout));
  dual_adc_if #(.DATA_W(W), .CONV_CYCLES(CONV), .ACCESS_DLY(ACC), .RELEASE_DLY(REL), .TWOS_COMP(1'b0))
    i_dual_adc_if_bin (.clk, .rst_n, .convst_n, .samp_a1(a1), .samp_a2(a2), .samp_b1(b1), .samp_b2(b2),
                       .cs_n, .rd_n, .chan_sel, .busy(busy_b), .data_oe(oe_b), .data_out(dout_b));

  function automatic logic [W-1:0] tc(input logic [W-1:0] s);
    tc = {~s[W-1], s[W-2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (busy) bcnt++;
    else if (bcnt != 0) begin last_len = bcnt; bcnt = 0; end
    if (oe && !oe_prev) begin
      if (rawq.size() == 0) check(1'b0, "R6 unexpected word", int'(dout), 0);
      else begin
        logic [W-1:0] r;
        string t;
        r = rawq.pop_front();
        t = tagq.pop_front();
        check(dout == tc(r), {t, " R8 twos"}, int'(dout), int'(tc(r)));
        check(dout_b == r, {t, " R8 binary"}, int'(dout_b), int'(r));
      end
    end
    oe_prev = oe;
  end

  task automatic do_read(input bit sel, input logic [W-1:0] raw, input string tag);
    chan_sel = sel; cs_n = 1'b0; rd_n = 1'b0;
    rawq.push_back(raw); tagq.push_back(tag);
    @(negedge clk);
    check(oe == 1'b0 && dout == '0, "R4 oe early", int'(oe), 0);
    @(negedge clk);
    check(oe == 1'b1, "R4 oe on", int'(oe), 1);
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    check(oe == 1'b1, "R5 oe held", int'(oe), 1);
    @(negedge clk);
    check(oe == 1'b0 && dout == '0, "R5 oe off", int'(oe), 0);
    @(negedge clk);
  endtask

  task automatic start_conv(input logic [W-1:0] x1, x2, y1, y2);
    a1 = x1; a2 = x2; b1 = y1; b2 = y2; convst_n = 1'b0;
    @(negedge clk);
    convst_n = 1'b1;
    check(busy == 1'b1, "R1 busy rises", int'(busy), 1);
    a1 = ~x1; a2 = ~x2; b1 = ~y1; b2 = ~y2;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
    check(last_len == CONV, "R1 busy length", last_len, CONV);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    check(oe == 1'b0 && dout == '0, "R4 reset bus", int'(dout), 0);

    start_conv(12'h123, 12'h8F0, 12'hFFF, 12'h000);
    wait_idle();
    do_read(1'b0, 12'h123, "R6 a1");
    do_read(1'b0, 12'h8F0, "R6 a2");
    do_read(1'b1, 12'hFFF, "R6 b1");
    do_read(1'b1, 12'h000, "R6 b2");
    do_read(1'b1, 12'hFFF, "R6 wrap b1");
    do_read(1'b0, 12'h123, "R7 sel change a1");

    start_conv(12'h456, 12'h789, 12'hABC, 12'hDEF);
    do_read(1'b0, 12'h8F0, "R3 read while busy old a2");
    check(busy == 1'b1, "R3 still busy", int'(busy), 1);
    wait_idle();
    do_read(1'b0, 12'h456, "R3 R7 new a1 after done");

    start_conv(12'h111, 12'h222, 12'h333, 12'h444);
    repeat (3) @(negedge clk);
    a1 = 12'h999; b1 = 12'h999; b2 = 12'h999;
    convst_n = 1'b0;
    @(negedge clk);
    convst_n = 1'b1;
    wait_idle();
    do_read(1'b1, 12'h333, "R2 b1 from first edge");
    do_read(1'b1, 12'h444, "R2 b2 from first edge");

    start_conv(12'h5A5, 12'h0F0, 12'h00F, 12'hF00);
    repeat (CONV - 1) @(negedge clk);
    check(busy == 1'b1, "R9 last busy cycle", int'(busy), 1);
    do_read(1'b0, 12'h111, "R9 collide old a1");
    check(last_len == CONV, "R9 busy length", last_len, CONV);
    do_read(1'b0, 12'h5A5, "R9 next new a1");

    check(rawq.size() == 0, "R4 pending words", rawq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule